// File: doc/BRIEF.md
# Flash Command Interface Controller

This block decodes the command stream that a host writes into a byte-wide flash device and sequences the resulting program and erase operations. Each bus write is either a command code or the second cycle of a two-cycle command. A program is a setup code followed by an address/data write. An erase is a setup code followed by a confirm write at an address inside the target block. Program and erase durations come from parameter-driven busy counters. At the end of its busy window each operation issues a one-cycle request to the external array.

An eight-bit status word shows whether the controller is busy, whether a program or an erase is suspended, and whether an error flag is set. The error flags cover a program error, an erase error, an invalid high-voltage supply and a protected block. A bus read returns array data, the status word or the electronic signature, depending on the read mode that earlier commands selected. The external array supplies the array data from the bus address. A program or erase may be suspended and then resumed. While an erase is suspended, the other blocks can be read and programmed.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the read mode is array, the status word reads 80h, and neither `pgm_req_o` nor `ers_req_o` is asserted.
- R2: A write of 40h or 10h followed by an address/data write starts a program. The status word reads 00h while it is busy. After PGM_CYCLES cycles, counted from the address/data write, `pgm_req_o` pulses for one cycle with that address and data. The read mode switches to status.
- R3: A write of 20h or 32h followed by a D0h write starts an erase of the block addressed by the top BLK_W address bits. After ERS_CYCLES cycles `ers_req_o` pulses with that block index, and reads then return 80h.
- R4: During erase setup, a second write whose data is not D0h cancels the erase and sets bits 5 and 4 together, so status reads B0h. No erase request follows.
- R5: While a program or erase is busy, only 70h (status) and B0h (suspend) are acted on. Every other write, FFh included, is ignored and reads keep returning status.
- R6: B0h during a busy operation freezes its counter. For a program, status reads 84h (bits 7 and 2). For an erase, status reads C0h (bits 7 and 6). D0h resumes the operation, which then finishes after only the cycles it had left. Bit 6 clears on an erase resume.
- R7: While an erase is suspended, an array read from another block returns array data, and a read from the suspended block returns status. A program to another block runs and issues its request. A program to the suspended block sets bit 4 and issues no request.
- R8: 70h selects status reads, FFh selects array reads, and 90h selects signature reads. A signature read returns 20h when address bit 0 is 0 and 28h when it is 1.
- R9: The status bits are laid out as follows. Bit 7 means ready. Bit 6 means erase suspended, bit 5 erase error, bit 4 program error, bit 3 supply invalid, bit 2 program suspended and bit 1 protected block. Bit 0 always reads 0.
- R10: A program to a block whose `wp_i` bit is set reads 92h (bits 4 and 1). An erase of such a block reads A2h (bits 5 and 1). Neither issues a request.
- R11: A program while `vpp_ok_i` is low reads 98h (bits 4 and 3). An erase while it is low reads A8h (bits 5 and 3). Neither issues a request.
- R12: The error flags hold until a 50h write clears them. While bit 4 or bit 5 is set, program and erase setup codes are ignored.
- R13: `rd_data_o` loads on the clock edge that samples `rd_i` and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Bus write strobe |
| rd_i | input | 1 | Bus read strobe |
| addr_i | input | ADDR_W | Bus address for both reads and writes |
| wdata_i | input | 8 | Bus write data (command code or program data) |
| arr_rdata_i | input | 8 | Array byte at `addr_i`, supplied by the array |
| wp_i | input | 2**BLK_W | Write protection, one bit per block |
| vpp_ok_i | input | 1 | High-voltage supply valid |
| rd_data_o | output | 8 | Registered bus read data |
| pgm_req_o | output | 1 | One-cycle array program request |
| pgm_addr_o | output | ADDR_W | Program address |
| pgm_data_o | output | 8 | Program data |
| ers_req_o | output | 1 | One-cycle block erase request |
| ers_blk_o | output | BLK_W | Index of the block to erase |

## Verification
The bench builds the block with ADDR_W=8 and BLK_W=2, which gives four blocks of 64 bytes, so every block, including the one an erase leaves suspended, lies within a short address sweep. PGM_CYCLES=5 and ERS_CYCLES=24 keep the busy windows short. These values let the bench measure exact cycle counts to each request, including the shortened counts after a resume. They also let it watch the full window for missing requests after rejected commands. An array model in the bench applies the requests, so program and erase results are checked by reading the array back.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PGM_SETUP,
    ST_ERS_SETUP,
    ST_PGM_BUSY,
    ST_ERS_BUSY,
    ST_PGM_SUSP
  } fsm_state_e;

  typedef enum logic [1:0] {
    RM_ARRAY,
    RM_STATUS,
    RM_SIG
  } rd_mode_e;

  typedef struct packed {
    logic ers_err;
    logic pgm_err;
    logic vpp_err;
    logic prot_err;
  } err_set_t;

  localparam logic [7:0] CMD_PGM_A   = 8'h40;
  localparam logic [7:0] CMD_PGM_B   = 8'h10;
  localparam logic [7:0] CMD_ERS_A   = 8'h20;
  localparam logic [7:0] CMD_ERS_B   = 8'h32;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_SIG     = 8'h90;
  localparam logic [7:0] CMD_CLR     = 8'h50;

endpackage

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= CNT_W'(CYCLES);
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = run_i && (cnt_q == CNT_W'(1));

  // the owner must drop run once the operation completes
  p_done_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
  import flash_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  err_set_t   set_i,
  input  logic       clr_i,
  input  logic       ready_i,
  input  logic       ers_susp_i,
  input  logic       pgm_susp_i,
  output logic [7:0] sr_o,
  output logic       op_err_o
);
  err_set_t err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_q <= '0;
    else if (clr_i) err_q <= set_i;
    else            err_q <= err_q | set_i;
  end

  assign sr_o = {ready_i, ers_susp_i, err_q.ers_err, err_q.pgm_err,
                 err_q.vpp_err, pgm_susp_i, err_q.prot_err, 1'b0};
  assign op_err_o = err_q.pgm_err | err_q.ers_err;

  p_err_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_o[5:4] != 2'b00 && !clr_i) |=> (sr_o[5:4] != 2'b00));

  p_err_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i == '0) |=> (sr_o[5:3] == 3'b000 && sr_o[1] == 1'b0));

endmodule

// File: rtl/flash_read_sel.sv
module flash_read_sel
  import flash_cmd_pkg::*;
#(
  parameter int          BLK_W  = 3,
  parameter logic [7:0]  MFR_ID = 8'h20,
  parameter logic [7:0]  DEV_ID = 8'h28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  rd_mode_e         rmode_i,
  input  logic [BLK_W-1:0] rblk_i,
  input  logic             sig_sel_i,
  input  logic [7:0]       arr_rdata_i,
  input  logic [7:0]       sr_i,
  input  logic             ers_susp_i,
  input  logic [BLK_W-1:0] ers_blk_i,
  output logic [7:0]       rd_data_o
);
  logic [7:0] sel_d;

  always_comb begin
    unique case (rmode_i)
      RM_ARRAY:  sel_d = (ers_susp_i && rblk_i == ers_blk_i) ? sr_i : arr_rdata_i;
      RM_SIG:    sel_d = sig_sel_i ? DEV_ID : MFR_ID;
      default:   sel_d = sr_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_data_o <= '0;
    else if (rd_i) rd_data_o <= sel_d;
  end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BLK_W  = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [7:0]             wdata_i,
  input  logic [(1<<BLK_W)-1:0]  wp_i,
  input  logic                   vpp_ok_i,
  input  logic                   op_err_i,
  input  logic                   pgm_done_i,
  input  logic                   ers_done_i,
  output logic                   ready_o,
  output logic                   pgm_susp_o,
  output logic                   ers_susp_o,
  output rd_mode_e               rmode_o,
  output err_set_t               err_set_o,
  output logic                   clr_o,
  output logic                   pgm_load_o,
  output logic                   ers_load_o,
  output logic                   pgm_run_o,
  output logic                   ers_run_o,
  output logic                   pgm_req_o,
  output logic [ADDR_W-1:0]      pgm_addr_o,
  output logic [7:0]             pgm_data_o,
  output logic                   ers_req_o,
  output logic [BLK_W-1:0]       ers_blk_o
);
  fsm_state_e        state_q, state_d;
  rd_mode_e          rmode_q, rmode_d;
  logic              ers_susp_q, ers_susp_d;
  logic [BLK_W-1:0]  ers_blk_q, ers_blk_d;
  logic [ADDR_W-1:0] pgm_addr_q, pgm_addr_d;
  logic [7:0]        pgm_data_q, pgm_data_d;
  logic              pgm_req_q, pgm_req_d, ers_req_q, ers_req_d;
  logic [BLK_W-1:0]  wblk;

  assign wblk = addr_i[ADDR_W-1 -: BLK_W];

  always_comb begin
    state_d    = state_q;
    rmode_d    = rmode_q;
    ers_susp_d = ers_susp_q;
    ers_blk_d  = ers_blk_q;
    pgm_addr_d = pgm_addr_q;
    pgm_data_d = pgm_data_q;
    pgm_req_d  = 1'b0;
    ers_req_d  = 1'b0;
    err_set_o  = '0;
    clr_o      = 1'b0;
    pgm_load_o = 1'b0;
    ers_load_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (wr_i) begin
        case (wdata_i)
          CMD_ARRAY:  rmode_d = RM_ARRAY;
          CMD_STATUS: rmode_d = RM_STATUS;
          CMD_SIG:    rmode_d = RM_SIG;
          CMD_CLR:    clr_o   = 1'b1;
          CMD_PGM_A, CMD_PGM_B: if (!op_err_i) state_d = ST_PGM_SETUP;
          CMD_ERS_A, CMD_ERS_B: if (!op_err_i && !ers_susp_q) state_d = ST_ERS_SETUP;
          CMD_CONFIRM: if (ers_susp_q) begin
            state_d    = ST_ERS_BUSY;
            ers_susp_d = 1'b0;
            rmode_d    = RM_STATUS;
          end
          default: ;
        endcase
      end
      ST_PGM_SETUP: if (wr_i) begin
        state_d = ST_IDLE;
        rmode_d = RM_STATUS;
        if (!vpp_ok_i)  begin err_set_o.vpp_err  = 1'b1; err_set_o.pgm_err = 1'b1; end
        if (wp_i[wblk]) begin err_set_o.prot_err = 1'b1; err_set_o.pgm_err = 1'b1; end
        if (ers_susp_q && wblk == ers_blk_q) err_set_o.pgm_err = 1'b1;
        if (!err_set_o.pgm_err) begin
          state_d    = ST_PGM_BUSY;
          pgm_addr_d = addr_i;
          pgm_data_d = wdata_i;
          pgm_load_o = 1'b1;
        end
      end
      ST_ERS_SETUP: if (wr_i) begin
        state_d = ST_IDLE;
        rmode_d = RM_STATUS;
        if (wdata_i != CMD_CONFIRM) begin
          err_set_o.ers_err = 1'b1;
          err_set_o.pgm_err = 1'b1;
        end else begin
          if (!vpp_ok_i)  begin err_set_o.vpp_err  = 1'b1; err_set_o.ers_err = 1'b1; end
          if (wp_i[wblk]) begin err_set_o.prot_err = 1'b1; err_set_o.ers_err = 1'b1; end
          if (!err_set_o.ers_err) begin
            state_d    = ST_ERS_BUSY;
            ers_blk_d  = wblk;
            ers_load_o = 1'b1;
          end
        end
      end
      ST_PGM_BUSY: begin
        if (pgm_done_i) begin
          state_d   = ST_IDLE;
          pgm_req_d = 1'b1;
        end else if (wr_i) begin
          if (wdata_i == CMD_STATUS) rmode_d = RM_STATUS;
          if (wdata_i == CMD_SUSPEND && !ers_susp_q) begin
            state_d = ST_PGM_SUSP;
            rmode_d = RM_STATUS;
          end
        end
      end
      ST_ERS_BUSY: begin
        if (ers_done_i) begin
          state_d   = ST_IDLE;
          ers_req_d = 1'b1;
        end else if (wr_i) begin
          if (wdata_i == CMD_STATUS) rmode_d = RM_STATUS;
          if (wdata_i == CMD_SUSPEND) begin
            state_d    = ST_IDLE;
            ers_susp_d = 1'b1;
            rmode_d    = RM_STATUS;
          end
        end
      end
      ST_PGM_SUSP: if (wr_i) begin
        case (wdata_i)
          CMD_ARRAY:  rmode_d = RM_ARRAY;
          CMD_STATUS: rmode_d = RM_STATUS;
          CMD_SIG:    rmode_d = RM_SIG;
          CMD_CONFIRM: begin
            state_d = ST_PGM_BUSY;
            rmode_d = RM_STATUS;
          end
          default: ;
        endcase
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      rmode_q    <= RM_ARRAY;
      ers_susp_q <= 1'b0;
      ers_blk_q  <= '0;
      pgm_addr_q <= '0;
      pgm_data_q <= '0;
      pgm_req_q  <= 1'b0;
      ers_req_q  <= 1'b0;
    end else begin
      state_q    <= state_d;
      rmode_q    <= rmode_d;
      ers_susp_q <= ers_susp_d;
      ers_blk_q  <= ers_blk_d;
      pgm_addr_q <= pgm_addr_d;
      pgm_data_q <= pgm_data_d;
      pgm_req_q  <= pgm_req_d;
      ers_req_q  <= ers_req_d;
    end
  end

  assign ready_o    = !(state_q == ST_PGM_BUSY || state_q == ST_ERS_BUSY);
  assign pgm_susp_o = (state_q == ST_PGM_SUSP);
  assign ers_susp_o = ers_susp_q;
  assign rmode_o    = rmode_q;
  assign pgm_run_o  = (state_q == ST_PGM_BUSY);
  assign ers_run_o  = (state_q == ST_ERS_BUSY);
  assign pgm_req_o  = pgm_req_q;
  assign pgm_addr_o = pgm_addr_q;
  assign pgm_data_o = pgm_data_q;
  assign ers_req_o  = ers_req_q;
  assign ers_blk_o  = ers_blk_q;

  p_susp_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ers_susp_q && state_q == ST_ERS_BUSY));

  p_req_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_req_q |=> !pgm_req_q);

  p_req_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pgm_req_q && ers_req_q));

  p_bad_confirm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERS_SETUP && wr_i && wdata_i != CMD_CONFIRM)
      |=> (state_q == ST_IDLE && !ers_req_q));

  p_busy_ignore_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERS_BUSY && wr_i && wdata_i == CMD_ARRAY) |=> rmode_q == RM_STATUS);

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W     = 19,
  parameter int         BLK_W      = 3,
  parameter int         PGM_CYCLES = 16,
  parameter int         ERS_CYCLES = 64,
  parameter logic [7:0] MFR_ID     = 8'h20,
  parameter logic [7:0] DEV_ID     = 8'h28
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [7:0]            wdata_i,
  input  logic [7:0]            arr_rdata_i,
  input  logic [(1<<BLK_W)-1:0] wp_i,
  input  logic                  vpp_ok_i,
  output logic [7:0]            rd_data_o,
  output logic                  pgm_req_o,
  output logic [ADDR_W-1:0]     pgm_addr_o,
  output logic [7:0]            pgm_data_o,
  output logic                  ers_req_o,
  output logic [BLK_W-1:0]      ers_blk_o
);
  logic       ready, pgm_susp, ers_susp, clr, op_err;
  logic       pgm_load, ers_load, pgm_run, ers_run, pgm_done, ers_done;
  rd_mode_e   rmode;
  err_set_t   err_set;
  logic [7:0] sr;

  flash_cmd_fsm #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_fsm (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .wp_i, .vpp_ok_i,
    .op_err_i(op_err), .pgm_done_i(pgm_done), .ers_done_i(ers_done),
    .ready_o(ready), .pgm_susp_o(pgm_susp), .ers_susp_o(ers_susp),
    .rmode_o(rmode), .err_set_o(err_set), .clr_o(clr),
    .pgm_load_o(pgm_load), .ers_load_o(ers_load),
    .pgm_run_o(pgm_run), .ers_run_o(ers_run),
    .pgm_req_o, .pgm_addr_o, .pgm_data_o, .ers_req_o, .ers_blk_o
  );

  flash_op_timer #(.CYCLES(PGM_CYCLES)) u_pgm_tmr (
    .clk_i, .rst_ni, .load_i(pgm_load), .run_i(pgm_run), .done_o(pgm_done)
  );

  flash_op_timer #(.CYCLES(ERS_CYCLES)) u_ers_tmr (
    .clk_i, .rst_ni, .load_i(ers_load), .run_i(ers_run), .done_o(ers_done)
  );

  flash_status_reg u_sr (
    .clk_i, .rst_ni, .set_i(err_set), .clr_i(clr), .ready_i(ready),
    .ers_susp_i(ers_susp), .pgm_susp_i(pgm_susp), .sr_o(sr), .op_err_o(op_err)
  );

  flash_read_sel #(.BLK_W(BLK_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rd (
    .clk_i, .rst_ni, .rd_i, .rmode_i(rmode),
    .rblk_i(addr_i[ADDR_W-1 -: BLK_W]), .sig_sel_i(addr_i[0]),
    .arr_rdata_i, .sr_i(sr), .ers_susp_i(ers_susp), .ers_blk_i(ers_blk_o),
    .rd_data_o
  );

  p_req_after_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pgm_req_o) |-> !$past(sr[7]));

  p_status_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rmode == RM_STATUS) |=> rd_data_o == $past(sr));

  p_sr0_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rd_data_o[0] == 1'b0 || $past(rmode) != RM_STATUS);

endmodule

// File: tb/flash_cmd_ctrl_test.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_test;
  localparam int AW = 8, BW = 2, PGM = 5, ERS = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0, vpp_ok = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [(1<<BW)-1:0] wp = '0;
  logic pgm_req, ers_req;
  logic [AW-1:0] pgm_addr;
  logic [7:0] pgm_data;
  logic [BW-1:0] ers_blk;
  logic [7:0] mem [1<<AW];
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .BLK_W(BW), .PGM_CYCLES(PGM), .ERS_CYCLES(ERS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata),
    .arr_rdata_i(mem[addr]), .wp_i(wp), .vpp_ok_i(vpp_ok), .rd_data_o(rdata),
    .pgm_req_o(pgm_req), .pgm_addr_o(pgm_addr), .pgm_data_o(pgm_data),
    .ers_req_o(ers_req), .ers_blk_o(ers_blk)
  );

  // array model
  always @(posedge clk) begin
    if (pgm_req) mem[pgm_addr] <= pgm_data;
    if (ers_req) for (int i = 0; i < (1 << (AW - BW)); i++) mem[{ers_blk, (AW-BW)'(i)}] <= 8'hFF;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_b(input logic [7:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_b(input logic [7:0] a, output logic [7:0] v);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    v = rdata;
  endtask

  task automatic wait_req(input bit erase, output int n);
    n = 0;
    while (!(erase ? ers_req : pgm_req) && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic quiet(input int cyc, input string tag);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (pgm_req || ers_req) seen++;
    end
    chk(tag, seen, 0);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 pgm_req idle", pgm_req, 0);
    chk("R1 ers_req idle", ers_req, 0);
    rd_b(8'h10, v); chk("R1 array mode after reset", v, 8'h4A);
    wr_b(0, 8'h70); rd_b(0, v); chk("R1 R9 status after reset", v, 8'h80);
  endtask

  task automatic t_signature;
    logic [7:0] v;
    wr_b(0, 8'h90);
    rd_b(8'h00, v); chk("R8 manufacturer code", v, 8'h20);
    rd_b(8'h01, v); chk("R8 device code", v, 8'h28);
    wr_b(0, 8'hFF);
    rd_b(8'h03, v); chk("R8 back to array", v, 8'h59);
  endtask

  task automatic t_program;
    logic [7:0] v; int n;
    wr_b(0, 8'h40); wr_b(8'h13, 8'hA5);
    wait_req(0, n);
    chk("R2 program latency", n, PGM);
    chk("R2 program addr", pgm_addr, 8'h13);
    chk("R2 program data", pgm_data, 8'hA5);
    @(negedge clk); chk("R2 single pulse", pgm_req, 0);
    rd_b(0, v); chk("R2 auto status after program", v, 8'h80);
    wr_b(0, 8'h10); wr_b(8'h14, 8'h3C);
    rd_b(0, v); chk("R2 busy status", v, 8'h00);
    wait_req(0, n); @(negedge clk);
    wr_b(0, 8'hFF);
    rd_b(8'h13, v); chk("R2 array programmed 40h", v, 8'hA5);
    rd_b(8'h14, v); chk("R2 array programmed 10h", v, 8'h3C);
  endtask

  task automatic t_erase;
    logic [7:0] v; int n;
    wr_b(0, 8'h20); wr_b(8'h40, 8'hD0);
    wait_req(1, n);
    chk("R3 erase latency", n, ERS);
    chk("R3 erase block", ers_blk, 1);
    @(negedge clk);
    rd_b(0, v); chk("R3 status after erase", v, 8'h80);
    wr_b(0, 8'hFF);
    rd_b(8'h45, v); chk("R3 erased byte", v, 8'hFF);
    rd_b(8'h85, v); chk("R3 other block intact", v, 8'hDF);
  endtask

  task automatic t_bad_confirm;
    logic [7:0] v;
    wr_b(0, 8'h20); wr_b(8'h40, 8'h55);
    rd_b(0, v); chk("R4 sequence error status", v, 8'hB0);
    quiet(ERS + 4, "R4 no erase request");
    wr_b(0, 8'h50); rd_b(0, v); chk("R4 R12 cleared", v, 8'h80);
  endtask

  task automatic t_busy_ignore;
    logic [7:0] v; int n;
    wr_b(0, 8'h32); wr_b(8'h80, 8'hD0);
    wr_b(0, 8'hFF);
    rd_b(8'h81, v); chk("R5 FFh ignored while busy", v, 8'h00);
    wr_b(0, 8'h90);
    rd_b(8'h81, v); chk("R5 90h ignored while busy", v, 8'h00);
    wait_req(1, n); chk("R5 erase unaffected", n, ERS - 4);
    @(negedge clk);
    wr_b(0, 8'hFF);
    rd_b(8'h81, v); chk("R3 32h erase done", v, 8'hFF);
  endtask

  task automatic t_pgm_suspend;
    logic [7:0] v; int n;
    wr_b(0, 8'h40); wr_b(8'h20, 8'h33); wr_b(0, 8'hB0);
    rd_b(0, v); chk("R6 program suspended status", v, 8'h84);
    quiet(12, "R6 no program while suspended");
    wr_b(0, 8'hD0);
    wait_req(0, n); chk("R6 program remaining cycles", n, PGM - 1);
    @(negedge clk);
    wr_b(0, 8'hFF);
    rd_b(8'h20, v); chk("R6 program result", v, 8'h33);
  endtask

  task automatic t_ers_suspend;
    logic [7:0] v; int n;
    wr_b(0, 8'h20); wr_b(8'hC0, 8'hD0); wr_b(0, 8'hB0);
    rd_b(0, v); chk("R6 erase suspended status", v, 8'hC0);
    wr_b(0, 8'hFF);
    rd_b(8'h05, v); chk("R7 read other block", v, 8'h5F);
    rd_b(8'hC1, v); chk("R7 read suspended block", v, 8'hC0);
    wr_b(0, 8'h40); wr_b(8'h06, 8'h12);
    wait_req(0, n); chk("R7 program other block", pgm_addr, 8'h06);
    @(negedge clk);
    rd_b(0, v); chk("R7 status after program", v, 8'hC0);
    wr_b(0, 8'h40); wr_b(8'hC2, 8'h00);
    rd_b(0, v); chk("R7 program suspended block rejected", v, 8'hD0);
    quiet(PGM + 3, "R7 no request for suspended block");
    wr_b(0, 8'h50);
    wr_b(0, 8'hD0);
    wait_req(1, n); chk("R6 erase remaining cycles", n, ERS - 1);
    chk("R6 erase block", ers_blk, 3);
    @(negedge clk);
    rd_b(0, v); chk("R6 suspend bit cleared", v, 8'h80);
    wr_b(0, 8'hFF);
    rd_b(8'h06, v); chk("R7 programmed during suspend", v, 8'h12);
    rd_b(8'hC2, v); chk("R6 resumed erase done", v, 8'hFF);
  endtask

  task automatic t_protect;
    logic [7:0] v;
    wp = 4'b0010;
    wr_b(0, 8'h40); wr_b(8'h50, 8'h00);
    rd_b(0, v); chk("R10 protected program", v, 8'h92);
    quiet(PGM + 3, "R10 no program request");
    wr_b(0, 8'h50);
    wr_b(0, 8'h20); wr_b(8'h50, 8'hD0);
    rd_b(0, v); chk("R10 protected erase", v, 8'hA2);
    quiet(ERS + 3, "R10 no erase request");
    wr_b(0, 8'h50); wp = '0;
  endtask

  task automatic t_vpp;
    logic [7:0] v;
    vpp_ok = 1'b0;
    wr_b(0, 8'h40); wr_b(8'h51, 8'h00);
    rd_b(0, v); chk("R11 program without supply", v, 8'h98);
    quiet(PGM + 3, "R11 no program request");
    wr_b(0, 8'h50);
    wr_b(0, 8'h32); wr_b(8'h51, 8'hD0);
    rd_b(0, v); chk("R11 erase without supply", v, 8'hA8);
    wr_b(0, 8'h50); vpp_ok = 1'b1;
  endtask

  task automatic t_sticky;
    logic [7:0] v; int n;
    wr_b(0, 8'h32); wr_b(0, 8'h00);
    wr_b(0, 8'hFF); wr_b(0, 8'h70);
    rd_b(0, v); chk("R12 error persists", v, 8'hB0);
    wr_b(0, 8'h40); wr_b(8'h07, 8'h00);
    quiet(PGM + 3, "R12 program blocked by error");
    wr_b(0, 8'hFF);
    rd_b(8'h07, v); chk("R12 array unchanged", v, 8'h5D);
    wr_b(0, 8'h50); wr_b(0, 8'h70);
    rd_b(0, v); chk("R12 clear", v, 8'h80);
    wr_b(0, 8'h40); wr_b(8'h07, 8'h00);
    wait_req(0, n); chk("R12 program after clear", n, PGM);
    @(negedge clk);
  endtask

  task automatic t_read_hold;
    logic [7:0] v;
    wr_b(0, 8'h90);
    rd_b(8'h01, v);
    addr = 8'h00;
    repeat (3) @(negedge clk);
    chk("R13 read data held", rdata, 8'h28);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    chk("R13 read data loads", rdata, 8'h20);
    wr_b(0, 8'hFF);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    wr_b(0, 8'hFF);
    t_signature();
    t_program();
    t_erase();
    t_bad_confirm();
    t_busy_ignore();
    t_pgm_suspend();
    t_ers_suspend();
    t_protect();
    t_vpp();
    t_sticky();
    t_read_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule